// File: doc/BRIEF.md
# Energy-to-Pulse Output Generator

This block turns a stream of signed per-sample power values into pulse trains. Two outputs drive a two-phase stepper motor or an electromechanical counter at a low rate. The third output is a faster calibration pulse. A flag shows the direction of power flow. Each valid sample adds its magnitude to two threshold accumulators. The low-rate accumulator uses a threshold picked by a two-bit rate select. The calibration accumulator uses that threshold divided by four or by eight, as chosen by a one-bit select. Each time an accumulator reaches its threshold, it subtracts the threshold, keeps the remainder, and queues one event.

A pulse shaper takes the queued events. Time in the shaper is counted in ticks of a fixed base clock, nominally 450 kHz, which arrive as a clock-enable input. Each pulse has a nominal width in ticks. When the spacing between pulse starts falls below twice that width, the pulse narrows to half the spacing. Low-rate events go alternately to the two stepper phases, and the two phases are never high together. The direction flag is refreshed only when a calibration pulse starts.

The sample stream comes from an upstream power computation. The reset is asynchronous, active low, and released synchronously inside the block.

Top module: `ep_pulse_out`

## Requirements
- R1: While `rst_n` is low, all four outputs, both accumulators, the event queues and the direction flag are cleared at once. Reset release takes effect two clock edges after `rst_n` rises.
- R2: Every cycle with `sample_valid` high adds |`power|` to the low-rate accumulator. The low-rate threshold is `LF_BASE` shifted left by `freq_sel` (values 0 to 3 give 1, 2, 4, 8 times `LF_BASE`). After the queue drains, the total number of low-rate pulses equals floor(total magnitude / threshold). No event is lost while fewer than 2^`PEND_W` events are waiting.
- R3: The calibration threshold is the low-rate threshold shifted right by 2 when `cal_sel` is 0 and by 3 when `cal_sel` is 1. The calibration pulse count is floor(total magnitude / that threshold).
- R4: Low-rate pulses alternate between `lf_a` and `lf_b`, and the first one after reset goes to `lf_a`. For N pulses, `lf_a` gets ceil(N/2) and `lf_b` gets floor(N/2).
- R5: A low-rate pulse is exactly `LF_WIDTH` ticks wide when the ticks since the previous start are at least 2·`LF_WIDTH`. The first pulse after reset is always full width, and no pulse is ever wider.
- R6: When the spacing P since the previous low-rate start is shorter than 2·`LF_WIDTH`, the pulse is max(1, floor(P/2)) ticks wide.
- R7: The calibration pulse follows R5 and R6 with `CAL_WIDTH` in place of `LF_WIDTH`.
- R8: `lf_a` and `lf_b` are never high together. Between any two low-rate pulses, both stay low for at least `MIN_GAP` ticks.
- R9: When a calibration pulse starts, `rev_flag` takes the sign of the most recent valid nonzero sample (1 = negative). At any other time it holds its value, whatever samples arrive.
- R10: Negative samples produce the same pulse counts as positive samples of equal magnitude.
- R11: Pulses start, and widths advance, only on cycles with `tick` high. Samples still accumulate and events stay queued while `tick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base-clock enable for all pulse timing |
| sample_valid | input | 1 | Qualifies `power` |
| power | input | POW_W | Signed power sample; magnitude below the calibration threshold |
| freq_sel | input | 2 | Low-rate scaling select |
| cal_sel | input | 1 | Calibration ratio select |
| lf_a | output | 1 | Stepper phase A pulse |
| lf_b | output | 1 | Stepper phase B pulse |
| cal_out | output | 1 | Calibration pulse |
| rev_flag | output | 1 | Reverse power flag |

## Verification
A wrong accumulator remainder or a dropped queued event shows only as a pulse count that differs by one or more. That difference appears after a whole run, so the bench counts edges after draining the queue. A bad spacing or width counter shows within one pulse as a wrong high-run length or a short low gap. The first pulse after reset exposes any error in the saturated initial state. A phase or direction register error appears at the very next pulse start: a pulse lands on the wrong stepper output, or the flag moves without a calibration edge.

// File: rtl/ep_pkg.sv
package ep_pkg;
  typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} ep_phase_e;
  localparam int EP_CH_LF  = 0;
  localparam int EP_CH_CAL = 1;
  localparam int EP_NCH    = 2;
endpackage

// File: rtl/ep_rstsync.sv
module ep_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ep_accum.sv
module ep_accum #(
  parameter int MAG_W = 17,
  parameter int THR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [MAG_W-1:0] mag,
  input  logic [THR_W-1:0] thr,
  output logic             evt
);
  localparam int SUM_W = ((MAG_W > THR_W) ? MAG_W : THR_W) + 1;

  logic [SUM_W-1:0] acc_q, acc_d, sum;
  logic             evt_q, evt_d;

  always_comb begin
    sum   = acc_q + SUM_W'(mag);
    acc_d = acc_q;
    evt_d = 1'b0;
    if (add_en) begin
      if (sum >= SUM_W'(thr)) begin
        acc_d = sum - SUM_W'(thr);
        evt_d = 1'b1;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      evt_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      evt_q <= evt_d;
    end
  end

  assign evt = evt_q;

  // R2
  evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> $past(add_en));
endmodule

// File: rtl/ep_shaper.sv
module ep_shaper #(
  parameter int WIDTH   = 20,
  parameter int MIN_GAP = 4,
  parameter int PEND_W  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic evt,
  output logic pulse,
  output logic start
);
  localparam int CNT_W   = $clog2(WIDTH + 1);
  localparam int EL_MAX  = 2 * WIDTH;
  localparam int EL_W    = $clog2(EL_MAX + 2);
  localparam int GAP_MAX = (MIN_GAP > 0) ? MIN_GAP - 1 : 0;
  localparam int GAP_W   = $clog2(GAP_MAX + 2);
  localparam logic [PEND_W-1:0] PEND_FULL = '1;

  logic              active_q, active_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, new_w;
  logic [EL_W-1:0]   el_q, el_d, period, half;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              gap_ok, issue, fall;

  always_comb begin
    gap_ok = (gap_q == GAP_W'(GAP_MAX));
    issue  = tick && (pend_q != '0) && !active_q && gap_ok;
    fall   = tick && active_q && (cnt_q == CNT_W'(1));
    period = el_q + EL_W'(1);
    half   = period >> 1;
    if (period >= EL_W'(EL_MAX)) new_w = CNT_W'(WIDTH);
    else if (half == '0)         new_w = CNT_W'(1);
    else                         new_w = CNT_W'(half);

    pend_d = pend_q;
    case ({evt, issue})
      2'b10:   if (pend_q != PEND_FULL) pend_d = pend_q + PEND_W'(1);
      2'b01:   pend_d = pend_q - PEND_W'(1);
      default: pend_d = pend_q;
    endcase

    active_d = active_q;
    cnt_d    = cnt_q;
    if (issue) begin
      active_d = 1'b1;
      cnt_d    = new_w;
    end else if (fall) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else if (tick && active_q) begin
      cnt_d    = cnt_q - CNT_W'(1);
    end

    el_d = el_q;
    if (issue)                                  el_d = '0;
    else if (tick && (el_q != EL_W'(EL_MAX)))   el_d = el_q + EL_W'(1);

    gap_d = gap_q;
    if (fall)                                                  gap_d = '0;
    else if (tick && !active_q && (gap_q != GAP_W'(GAP_MAX)))  gap_d = gap_q + GAP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      el_q     <= EL_W'(EL_MAX);
      gap_q    <= GAP_W'(GAP_MAX);
      pend_q   <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      el_q     <= el_d;
      gap_q    <= gap_d;
      pend_q   <= pend_d;
    end
  end

  assign pulse = active_q;
  assign start = issue;

  // R5
  width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WIDTH));

  // R2
  rise_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> ($past(pend_q) != '0));
endmodule

// File: rtl/ep_pulse_out.sv
module ep_pulse_out
  import ep_pkg::*;
#(
  parameter int POW_W        = 16,
  parameter int LF_BASE      = 256,
  parameter int LF_WIDTH     = 54000,
  parameter int CAL_WIDTH    = 40500,
  parameter int MIN_GAP      = 4,
  parameter int CAL_SHIFT_LO = 2,
  parameter int CAL_SHIFT_HI = 3,
  parameter int PEND_W       = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    sample_valid,
  input  logic signed [POW_W-1:0] power,
  input  logic [1:0]              freq_sel,
  input  logic                    cal_sel,
  output logic                    lf_a,
  output logic                    lf_b,
  output logic                    cal_out,
  output logic                    rev_flag
);
  localparam int MAG_W = POW_W + 1;
  localparam int THR_W = $clog2(LF_BASE) + 4;

  logic                     rst_sync_n;
  logic signed [MAG_W-1:0]  pw_ext;
  logic [MAG_W-1:0]         mag;
  logic [THR_W-1:0]         thr [EP_NCH];
  logic [EP_NCH-1:0]        evt, pulse, start;

  ep_phase_e cur_q, cur_d, nxt_q, nxt_d;
  logic      rev_q, rev_d, last_neg_q, last_neg_d;

  ep_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    pw_ext = {power[POW_W-1], power};
    mag    = pw_ext[MAG_W-1] ? MAG_W'(-pw_ext) : MAG_W'(pw_ext);
    thr[EP_CH_LF]  = THR_W'(LF_BASE) << freq_sel;
    thr[EP_CH_CAL] = thr[EP_CH_LF] >> (cal_sel ? CAL_SHIFT_HI : CAL_SHIFT_LO);
  end

  for (genvar g = 0; g < EP_NCH; g++) begin : g_chan
    localparam int W   = (g == EP_CH_LF) ? LF_WIDTH : CAL_WIDTH;
    localparam int GAP = (g == EP_CH_LF) ? MIN_GAP  : 1;

    ep_accum #(.MAG_W(MAG_W), .THR_W(THR_W)) u_acc (
      .clk(clk), .rst_n(rst_sync_n), .add_en(sample_valid),
      .mag(mag), .thr(thr[g]), .evt(evt[g])
    );

    ep_shaper #(.WIDTH(W), .MIN_GAP(GAP), .PEND_W(PEND_W)) u_shp (
      .clk(clk), .rst_n(rst_sync_n), .tick(tick), .evt(evt[g]),
      .pulse(pulse[g]), .start(start[g])
    );
  end

  always_comb begin
    last_neg_d = last_neg_q;
    if (sample_valid && (power != '0)) last_neg_d = power[POW_W-1];

    rev_d = rev_q;
    if (start[EP_CH_CAL]) rev_d = last_neg_q;

    cur_d = cur_q;
    nxt_d = nxt_q;
    if (start[EP_CH_LF]) begin
      cur_d = nxt_q;
      nxt_d = (nxt_q == PH_A) ? PH_B : PH_A;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      last_neg_q <= 1'b0;
      rev_q      <= 1'b0;
      cur_q      <= PH_A;
      nxt_q      <= PH_A;
    end else begin
      last_neg_q <= last_neg_d;
      rev_q      <= rev_d;
      cur_q      <= cur_d;
      nxt_q      <= nxt_d;
    end
  end

  assign lf_a     = pulse[EP_CH_LF] && (cur_q == PH_A);
  assign lf_b     = pulse[EP_CH_LF] && (cur_q == PH_B);
  assign cal_out  = pulse[EP_CH_CAL];
  assign rev_flag = rev_q;

  // R8
  lf_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(lf_a && lf_b));

  // R9
  rev_on_cal_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rev_q != $past(rev_q)) |-> $rose(pulse[EP_CH_CAL]));

  // R4
  phase_swap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(pulse[EP_CH_LF]) && $past(cur_q == PH_A) && $past(nxt_q == PH_B)) |-> (cur_q == PH_B));
endmodule

// File: tb/test_ep_pulse_out.sv
module test_ep_pulse_out;
  localparam int CLK_PERIOD = 10;
  localparam int LFW  = 20;
  localparam int CALW = 6;
  localparam int GAPW = 4;
  localparam int BASE = 256;

  typedef struct packed {
    int       pwr;
    logic [1:0] fs;
    logic     cs;
    int       n;
    int       lf_mode;   // 0 full width, 1 narrowed, 2 no pulses
    int       cal_mode;
  } vec_t;

  // R10: negative rows must count like positive ones
  localparam vec_t VECS [6] = '{
    '{  5, 2'd0, 1'b0, 1000, 0, 0},
    '{-10, 2'd0, 1'b1,  800, 1, 1},
    '{ 20, 2'd1, 1'b0, 1000, 1, 1},
    '{ -3, 2'd2, 1'b1, 2000, 0, 0},
    '{ 30, 2'd3, 1'b0, 1000, 0, 0},
    '{  0, 2'd0, 1'b0,  500, 2, 2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic sample_valid = 1'b0;
  logic signed [15:0] power = '0;
  logic [1:0] freq_sel = '0;
  logic cal_sel = 1'b0;
  logic lf_a, lf_b, cal_out, rev_flag;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  ep_pulse_out #(.POW_W(16), .LF_BASE(BASE), .LF_WIDTH(LFW), .CAL_WIDTH(CALW),
                 .MIN_GAP(GAPW)) i_ep_pulse_out (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sample_valid(sample_valid),
    .power(power), .freq_sel(freq_sel), .cal_sel(cal_sel),
    .lf_a(lf_a), .lf_b(lf_b), .cal_out(cal_out), .rev_flag(rev_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor state
  bit mon_en = 1'b0;
  logic pa = 0, pb = 0, pc = 0, pr = 0;
  int rise_a, rise_b, rise_c, overlap, rev_bad;
  int lf_run, lf_low, lf_min, lf_max, gap_min, cal_run, cal_min, cal_max;
  bit seen_fall;

  task automatic clear_stats();
    rise_a = 0; rise_b = 0; rise_c = 0; overlap = 0; rev_bad = 0;
    lf_run = 0; lf_low = 0; lf_min = 1000; lf_max = 0; gap_min = 1000;
    cal_run = 0; cal_min = 1000; cal_max = 0; seen_fall = 0;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (lf_a && !pa) rise_a++;
      if (lf_b && !pb) rise_b++;
      if (cal_out && !pc) rise_c++;
      if (lf_a && lf_b) overlap++;
      if (lf_a || lf_b) begin
        if (!(pa || pb) && seen_fall && lf_low < gap_min) gap_min = lf_low;
        lf_run = (pa || pb) ? lf_run + 1 : 1;
      end else begin
        if (pa || pb) begin
          if (lf_run < lf_min) lf_min = lf_run;
          if (lf_run > lf_max) lf_max = lf_run;
          seen_fall = 1'b1;
          lf_low = 1;
        end else lf_low++;
      end
      if (cal_out) cal_run = pc ? cal_run + 1 : 1;
      else if (pc) begin
        if (cal_run < cal_min) cal_min = cal_run;
        if (cal_run > cal_max) cal_max = cal_run;
      end
      if ((rev_flag != pr) && !(cal_out && !pc)) rev_bad++;
    end
    pa = lf_a; pb = lf_b; pc = cal_out; pr = rev_flag;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    mon_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    sample_valid = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(3);
    clear_stats();
    mon_en = 1'b1;
  endtask

  task automatic feed(input int p, input int n);
    power = 16'(p);
    sample_valid = 1'b1;
    cycles(n);
    sample_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #1;
    check(!lf_a && !lf_b && !cal_out && !rev_flag, "R1 reset outputs",
          {lf_a, lf_b, cal_out, rev_flag}, 0);

    for (int v = 0; v < 6; v++) begin
      int ap, thr, cthr, e, elf, ecal;
      ap   = (VECS[v].pwr < 0) ? -VECS[v].pwr : VECS[v].pwr;
      thr  = BASE << VECS[v].fs;
      cthr = thr >> (VECS[v].cs ? 3 : 2);
      e    = ap * VECS[v].n;
      elf  = e / thr;
      ecal = e / cthr;
      freq_sel = VECS[v].fs;
      cal_sel  = VECS[v].cs;
      tick     = 1'b1;
      do_reset();
      feed(VECS[v].pwr, VECS[v].n);
      cycles(400);
      check(rise_a == (elf + 1) / 2, "R2/R4/R10 lf_a count", rise_a, (elf + 1) / 2);
      check(rise_b == elf / 2, "R2/R4/R10 lf_b count", rise_b, elf / 2);
      check(rise_c == ecal, "R3/R10 cal count", rise_c, ecal);
      check(rev_flag == ((VECS[v].pwr < 0) && ecal > 0), "R9 rev final",
            rev_flag, (VECS[v].pwr < 0) && ecal > 0);
      check(rev_bad == 0, "R9 rev moved off cal edge", rev_bad, 0);
      check(overlap == 0, "R8 overlap", overlap, 0);
      if (elf > 1) check(gap_min >= GAPW, "R8 low gap", gap_min, GAPW);
      if (VECS[v].lf_mode != 2) begin
        check(lf_max == LFW, "R5 lf max width", lf_max, LFW);
        if (VECS[v].lf_mode == 0) check(lf_min == LFW, "R5 lf min width", lf_min, LFW);
        else check(lf_min < LFW && lf_min >= 1, "R6 lf narrowed", lf_min, LFW / 2);
      end
      if (VECS[v].cal_mode != 2) begin
        check(cal_max == CALW, "R7 cal max width", cal_max, CALW);
        if (VECS[v].cal_mode == 0) check(cal_min == CALW, "R7 cal min width", cal_min, CALW);
        else check(cal_min < CALW && cal_min >= 1, "R7 cal narrowed", cal_min, CALW / 2);
      end
    end

    // R11: no progress without tick, events kept
    freq_sel = 2'd0; cal_sel = 1'b0;
    do_reset();
    tick = 1'b0;
    feed(30, 10);
    cycles(20);
    check(!lf_a && !cal_out, "R11 no start without tick", {lf_a, cal_out}, 0);
    tick = 1'b1;
    cycles(1);
    check(lf_a && cal_out, "R11 start on tick", {lf_a, cal_out}, 3);
    tick = 1'b0;
    cycles(30);
    check(lf_a, "R11 width frozen", lf_a, 1);
    tick = 1'b1;
    cycles(200);
    check(rise_c == 4, "R11 cal events kept", rise_c, 4);
    check(rise_a == 1 && rise_b == 0, "R4 first on lf_a", rise_a, 1);
    check(lf_max == LFW + 30, "R11 width counts ticks only", lf_max, LFW + 30);

    // R9: flag holds between cal pulses
    freq_sel = 2'd0; cal_sel = 1'b1;
    do_reset();
    feed(-10, 96);
    cycles(150);
    check(rev_flag == 1'b1, "R9 negative flow", rev_flag, 1);
    begin
      int rc;
      rc = rise_c;
      feed(5, 6);
      cycles(60);
      check(rev_flag == 1'b1, "R9 held without cal pulse", rev_flag, 1);
      check(rise_c == rc, "R9 no cal pulse", rise_c, rc);
      feed(5, 1);
      cycles(60);
      check(rise_c == rc + 1, "R3 cal after crossing", rise_c, rc + 1);
      check(rev_flag == 1'b0, "R9 cleared at cal pulse", rev_flag, 0);
      check(rev_bad == 0, "R9 rev moved off cal edge", rev_bad, 0);
    end

    // R1: asynchronous clear in mid-pulse
    freq_sel = 2'd0; cal_sel = 1'b0;
    do_reset();
    feed(30, 20);
    check(lf_a == 1'b1, "R4 lf_a high before reset", lf_a, 1);
    #2 rst_n = 1'b0;
    #1 check(!lf_a && !lf_b && !cal_out && !rev_flag, "R1 async clear",
             {lf_a, lf_b, cal_out, rev_flag}, 0);
    mon_en = 1'b0;
    cycles(2);
    rst_n = 1'b1;
    cycles(1);
    check(!lf_a && !cal_out, "R1 held during release", {lf_a, cal_out}, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule